// File: doc/BRIEF.md
# IDE DMA Transfer Sequencer

This block runs one DMA transfer between an IDE device model, either a disk or a packet (optical) device, and a descriptor-driven DMA channel. A start pulse carries the drive kind, the command, the sector count or packet byte count, and the starting sector or LBA. The block works out how many bytes are left to move, raises its active flag and then takes descriptors one at a time. Each descriptor gives a memory address and a byte length.

For every descriptor with a nonzero length, the block issues one storage request. The request carries the byte offset into the medium, the memory address, the length and the operation. The block waits for the storage response before it takes the next descriptor. After each request it lowers the remaining byte count and advances the running byte index.

The transfer ends when the remaining count reaches zero or drops below it, or when the storage side reports an error. At that point the block updates an IDE-style status byte and raises a level interrupt that stays high until the next start.

A packet transfer whose LBA is all ones carries no block data. It becomes a single direct copy that is clipped to the smaller of the remaining count and the descriptor length. A descriptor that arrives while the block is inactive is parked: it is shown as waiting but is not taken.

Top module: `ide_dma_seq`

## Requirements
- R1: After reset, the outputs are as follows: status is 0x00, irq is 0, active is 0, desc_ready is 0 and sto_req_valid is 0.
- R2: A start pulse while inactive, with a legal command, sets active to 1, sets status to 0x80 (busy) and clears irq, all on the next cycle. A start pulse while active is ignored.
- R3: For a disk, the transfer size is the sector count × 512. When active and the remaining count is zero or less, the block goes inactive. It then sets status to 0x50 (ready 0x40 plus seek-complete 0x10) and raises irq. A sector count of zero therefore finishes with no descriptor. A last descriptor longer than what remains is still requested at its full length.
- R4: For a packet device, the transfer size is the given packet byte count.
- R5: The request offset is LBA×512 plus the running index for a disk, and LBA×2048 plus the running index for a packet device. The index starts at 0 and grows by each requested length.
- R6: The sto_req_op encoding is 0 read, 1 write, 2 trim and 3 direct copy. Disk commands (start_cmd 0 read, 1 write, 2 trim) map one to one onto these codes. A packet block transfer always uses op 0.
- R7: start_cmd 3 on a disk is illegal. The block stays inactive, sets status to 0x41 (ready plus error 0x01) and raises irq.
- R8: While inactive, a valid descriptor is not taken. desc_ready stays 0, desc_parked is 1 and no request is issued.
- R9: A descriptor of length 0 is taken without a storage request, and the block keeps waiting for descriptors.
- R10: For a packet device with an all-ones LBA, the block issues one request with op 3, offset 0 and length min(remaining, descriptor length). Its successful response ends the transfer with status 0x50 and irq.
- R11: A storage response with the error flag ends the transfer. Status becomes 0x41, irq is raised and active drops.
- R12: Only one request is outstanding at a time. desc_ready stays 0 from the moment a nonzero descriptor is taken until its response returns.
- R13: A request stays valid with its op, offset and length unchanged until sto_req_ready is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Start pulse |
| start_packet | input | 1 | 1 = packet device, 0 = disk |
| start_cmd | input | 2 | Disk command: 0 read, 1 write, 2 trim, 3 illegal |
| start_nsect | input | NSW (16) | Disk sector count |
| start_lba | input | LBAW (32) | Starting sector or packet LBA |
| start_pkt_bytes | input | CNTW (24) | Packet transfer byte count |
| desc_valid | input | 1 | Descriptor offered |
| desc_addr | input | ADDRW (32) | Descriptor memory address |
| desc_len | input | LENW (16) | Descriptor byte length |
| desc_ready | output | 1 | Descriptor taken when high with desc_valid |
| desc_parked | output | 1 | Descriptor waiting while inactive |
| sto_req_valid | output | 1 | Storage request valid |
| sto_req_ready | input | 1 | Storage request accepted |
| sto_req_op | output | 2 | Operation code |
| sto_req_offset | output | OFFW (48) | Byte offset into the medium |
| sto_req_addr | output | ADDRW (32) | Memory address |
| sto_req_len | output | LENW (16) | Byte length |
| sto_rsp_valid | input | 1 | Storage response |
| sto_rsp_err | input | 1 | Response carries an error |
| status | output | 8 | IDE status byte |
| irq | output | 1 | Completion interrupt, level |
| active | output | 1 | Transfer in progress |

## Verification
The edge that samples a start pulse also changes active and status, so the bench reads them at the next falling edge. A descriptor taken at one edge shows up as sto_req_valid, with its offset, by the following falling edge. After the response edge, one more edge is needed to judge the remaining count before completion shows. The bench therefore polls for the request and for the end of the transfer with bounded loops, and reads every output half a period after the edge that updates it. It checks "ignored" and "parked" cases through the offsets and handshake outputs that would have changed.

// File: rtl/ide_dma_pkg.sv
package ide_dma_pkg;

    typedef enum logic [1:0] {
        CMD_READ  = 2'd0,
        CMD_WRITE = 2'd1,
        CMD_TRIM  = 2'd2,
        CMD_BAD   = 2'd3
    } dma_cmd_e;

    typedef enum logic [1:0] {
        OP_READ  = 2'd0,
        OP_WRITE = 2'd1,
        OP_TRIM  = 2'd2,
        OP_COPY  = 2'd3
    } sto_op_e;

    typedef enum logic [1:0] {
        S_IDLE,
        S_WAIT_DESC,
        S_ISSUE,
        S_WAIT_RSP
    } seq_state_e;

    typedef struct packed {
        logic start_ok;
        logic start_bad;
        logic done_ok;
        logic done_err;
    } seq_event_t;

    localparam logic [7:0] ST_BUSY  = 8'h80;
    localparam logic [7:0] ST_READY = 8'h40;
    localparam logic [7:0] ST_SEEK  = 8'h10;
    localparam logic [7:0] ST_ERR   = 8'h01;

    localparam int DISK_SHIFT   = 9;
    localparam int PACKET_SHIFT = 11;

    function automatic sto_op_e op_for(logic is_packet, dma_cmd_e cmd);
        if (is_packet) return OP_READ;
        case (cmd)
            CMD_WRITE: return OP_WRITE;
            CMD_TRIM:  return OP_TRIM;
            default:   return OP_READ;
        endcase
    endfunction

endpackage

// File: rtl/ide_dma_offset.sv
module ide_dma_offset #(
    parameter int LBAW = 32,
    parameter int IDXW = 27,
    parameter int OFFW = 48
) (
    input  logic            is_packet,
    input  logic [LBAW-1:0] lba,
    input  logic [IDXW-1:0] index,
    output logic [OFFW-1:0] offset
);
    import ide_dma_pkg::*;

    logic [OFFW-1:0] base_w;

    always_comb begin
        if (is_packet) base_w = OFFW'(lba) << PACKET_SHIFT;
        else           base_w = OFFW'(lba) << DISK_SHIFT;
        offset = base_w + OFFW'(index);
    end

endmodule

// File: rtl/ide_dma_status.sv
module ide_dma_status (
    input  logic                    clk,
    input  logic                    rst,
    input  ide_dma_pkg::seq_event_t ev,
    output logic [7:0]              status,
    output logic                    irq
);
    import ide_dma_pkg::*;

    always_ff @(posedge clk) begin
        if (rst) begin
            status <= 8'h00;
            irq    <= 1'b0;
        end else if (ev.start_bad) begin
            status <= ST_READY | ST_ERR;
            irq    <= 1'b1;
        end else if (ev.start_ok) begin
            status <= ST_BUSY;
            irq    <= 1'b0;
        end else if (ev.done_err) begin
            status <= ST_READY | ST_ERR;
            irq    <= 1'b1;
        end else if (ev.done_ok) begin
            status <= ST_READY | ST_SEEK;
            irq    <= 1'b1;
        end
    end

    // R3: the interrupt holds until a new transfer starts
    p_irq_sticky_r3: assert property (@(posedge clk) disable iff (rst)
        irq && !ev.start_ok |=> irq);

endmodule

// File: rtl/ide_dma_seq.sv
module ide_dma_seq #(
    parameter int LBAW  = 32,
    parameter int NSW   = 16,
    parameter int CNTW  = 24,
    parameter int LENW  = 16,
    parameter int ADDRW = 32,
    parameter int OFFW  = 48
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             start_packet,
    input  logic [1:0]       start_cmd,
    input  logic [NSW-1:0]   start_nsect,
    input  logic [LBAW-1:0]  start_lba,
    input  logic [CNTW-1:0]  start_pkt_bytes,
    input  logic             desc_valid,
    input  logic [ADDRW-1:0] desc_addr,
    input  logic [LENW-1:0]  desc_len,
    output logic             desc_ready,
    output logic             desc_parked,
    output logic             sto_req_valid,
    input  logic             sto_req_ready,
    output logic [1:0]       sto_req_op,
    output logic [OFFW-1:0]  sto_req_offset,
    output logic [ADDRW-1:0] sto_req_addr,
    output logic [LENW-1:0]  sto_req_len,
    input  logic             sto_rsp_valid,
    input  logic             sto_rsp_err,
    output logic [7:0]       status,
    output logic             irq,
    output logic             active
);
    import ide_dma_pkg::*;

    localparam int DSKW = NSW + DISK_SHIFT;
    localparam int SZW  = (CNTW > DSKW) ? CNTW : DSKW;
    localparam int RW   = ((SZW > LENW) ? SZW : LENW) + 2;

    seq_state_e             state;
    logic                   is_pkt;
    dma_cmd_e               cmd_q;
    logic [LBAW-1:0]        lba_q;
    logic signed [RW-1:0]   remaining;
    logic [RW-1:0]          index;
    logic                   copy_mode;
    sto_op_e                req_op;
    logic [OFFW-1:0]        req_offset;
    logic [ADDRW-1:0]       req_addr;
    logic [LENW-1:0]        req_len;
    logic [OFFW-1:0]        off_w;
    logic [LENW-1:0]        clip_len;
    seq_event_t             ev;
    logic                   start_go, start_bad, finish, accept, blk_copy, has_left, rsp_in;

    ide_dma_offset #(.LBAW(LBAW), .IDXW(RW), .OFFW(OFFW)) u_offset (
        .is_packet (is_pkt),
        .lba       (lba_q),
        .index     (index),
        .offset    (off_w)
    );

    ide_dma_status u_status (
        .clk    (clk),
        .rst    (rst),
        .ev     (ev),
        .status (status),
        .irq    (irq)
    );

    always_comb begin
        has_left   = remaining > 0;
        active     = state != S_IDLE;
        desc_ready = (state == S_WAIT_DESC) && has_left;
        desc_parked = desc_valid && (state == S_IDLE);
        finish     = (state == S_WAIT_DESC) && !has_left;
        accept     = desc_valid && desc_ready;
        blk_copy   = is_pkt && (&lba_q);
        rsp_in     = (state == S_WAIT_RSP) && sto_rsp_valid;
        start_go   = start && (state == S_IDLE);
        start_bad  = start_go && !start_packet && (dma_cmd_e'(start_cmd) == CMD_BAD);
        clip_len   = ($unsigned(remaining) < RW'(desc_len)) ? LENW'(remaining) : desc_len;
        ev.start_ok  = start_go && !start_bad;
        ev.start_bad = start_bad;
        ev.done_err  = rsp_in && sto_rsp_err;
        ev.done_ok   = finish || (rsp_in && !sto_rsp_err && copy_mode);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= S_IDLE;
            is_pkt     <= 1'b0;
            cmd_q      <= CMD_READ;
            lba_q      <= '0;
            remaining  <= '0;
            index      <= '0;
            copy_mode  <= 1'b0;
            req_op     <= OP_READ;
            req_offset <= '0;
            req_addr   <= '0;
            req_len    <= '0;
        end else begin
            case (state)
                S_IDLE: if (ev.start_ok) begin
                    is_pkt <= start_packet;
                    cmd_q  <= dma_cmd_e'(start_cmd);
                    lba_q  <= start_lba;
                    index  <= '0;
                    if (start_packet) remaining <= RW'(start_pkt_bytes);
                    else              remaining <= RW'(start_nsect) << DISK_SHIFT;
                    state  <= S_WAIT_DESC;
                end
                S_WAIT_DESC: begin
                    if (finish) begin
                        state <= S_IDLE;
                    end else if (accept && desc_len != '0) begin
                        req_addr <= desc_addr;
                        if (blk_copy) begin
                            req_op     <= OP_COPY;
                            req_offset <= '0;
                            req_len    <= clip_len;
                            copy_mode  <= 1'b1;
                        end else begin
                            req_op     <= op_for(is_pkt, cmd_q);
                            req_offset <= off_w;
                            req_len    <= desc_len;
                            remaining  <= remaining - RW'(desc_len);
                            index      <= index + RW'(desc_len);
                            copy_mode  <= 1'b0;
                        end
                        state <= S_ISSUE;
                    end
                end
                S_ISSUE: if (sto_req_ready) state <= S_WAIT_RSP;
                S_WAIT_RSP: if (sto_rsp_valid) begin
                    state <= (sto_rsp_err || copy_mode) ? S_IDLE : S_WAIT_DESC;
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    assign sto_req_valid  = state == S_ISSUE;
    assign sto_req_op     = req_op;
    assign sto_req_offset = req_offset;
    assign sto_req_addr   = req_addr;
    assign sto_req_len    = req_len;

    // R13: a request holds still until it is accepted
    p_req_hold_r13: assert property (@(posedge clk) disable iff (rst)
        sto_req_valid && !sto_req_ready |=> sto_req_valid && $stable(sto_req_offset)
            && $stable(sto_req_len) && $stable(sto_req_op));

    // R12: taking a nonzero descriptor closes the descriptor port
    p_single_req_r12: assert property (@(posedge clk) disable iff (rst)
        accept && desc_len != '0 |=> !desc_ready);

    // R8: a parked descriptor never launches a request
    p_parked_r8: assert property (@(posedge clk) disable iff (rst)
        desc_parked |=> !sto_req_valid);

    // R3: the interrupt rises only as the transfer goes inactive
    p_done_idle_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> !active);

    // R2: a legal start shows busy with the interrupt cleared
    p_start_busy_r2: assert property (@(posedge clk) disable iff (rst)
        start && !active && (start_packet || start_cmd != 2'd3)
            |=> status == 8'h80 && !irq && active);

endmodule

// File: tb/test_ide_dma_seq.sv
`timescale 1ns/1ps
module test_ide_dma_seq;

    logic        clk = 1'b0;
    logic        rst;
    logic        start, start_packet;
    logic [1:0]  start_cmd;
    logic [15:0] start_nsect;
    logic [31:0] start_lba;
    logic [23:0] start_pkt_bytes;
    logic        desc_valid;
    logic [31:0] desc_addr;
    logic [15:0] desc_len;
    logic        desc_ready, desc_parked;
    logic        sto_req_valid, sto_req_ready;
    logic [1:0]  sto_req_op;
    logic [47:0] sto_req_offset;
    logic [31:0] sto_req_addr;
    logic [15:0] sto_req_len;
    logic        sto_rsp_valid, sto_rsp_err;
    logic [7:0]  status;
    logic        irq, active;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    ide_dma_seq i_ide_dma_seq (
        .clk(clk), .rst(rst), .start(start), .start_packet(start_packet),
        .start_cmd(start_cmd), .start_nsect(start_nsect), .start_lba(start_lba),
        .start_pkt_bytes(start_pkt_bytes), .desc_valid(desc_valid),
        .desc_addr(desc_addr), .desc_len(desc_len), .desc_ready(desc_ready),
        .desc_parked(desc_parked), .sto_req_valid(sto_req_valid),
        .sto_req_ready(sto_req_ready), .sto_req_op(sto_req_op),
        .sto_req_offset(sto_req_offset), .sto_req_addr(sto_req_addr),
        .sto_req_len(sto_req_len), .sto_rsp_valid(sto_rsp_valid),
        .sto_rsp_err(sto_rsp_err), .status(status), .irq(irq), .active(active)
    );

    task automatic chk(string rq, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
        end
    endtask

    task automatic do_start(bit pkt, bit [1:0] cmd, int ns, bit [31:0] lba, int bytes);
        start_packet = pkt; start_cmd = cmd; start_nsect = 16'(ns);
        start_lba = lba; start_pkt_bytes = 24'(bytes); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic send_desc(bit [31:0] addr, int len);
        desc_addr = addr; desc_len = 16'(len); desc_valid = 1'b1;
        for (int n = 0; n < 50 && !desc_ready; n++) @(negedge clk);
        @(negedge clk);
        desc_valid = 1'b0;
    endtask

    task automatic serve(string rq, int op, longint off, int len, bit err, bit stall);
        for (int n = 0; n < 50 && !sto_req_valid; n++) @(negedge clk);
        chk(rq, sto_req_valid, 1);
        chk(rq, sto_req_op, op);
        chk(rq, sto_req_offset, off);
        chk(rq, sto_req_len, len);
        chk("R12", desc_ready, 0);
        if (stall) begin
            @(negedge clk);
            chk("R13", sto_req_valid, 1);
            chk("R13", sto_req_offset, off);
        end
        sto_req_ready = 1'b1;
        @(negedge clk);
        sto_req_ready = 1'b0;
        chk("R12", desc_ready, 0);
        sto_rsp_valid = 1'b1; sto_rsp_err = err;
        @(negedge clk);
        sto_rsp_valid = 1'b0; sto_rsp_err = 1'b0;
    endtask

    task automatic wait_end(string rq, int exp_status);
        for (int n = 0; n < 20 && active; n++) @(negedge clk);
        chk(rq, active, 0);
        chk(rq, status, exp_status);
        chk(rq, irq, 1);
    endtask

    task automatic t_reset;
        chk("R1", status, 8'h00);
        chk("R1", irq, 0);
        chk("R1", active, 0);
        chk("R1", desc_ready, 0);
        chk("R1", sto_req_valid, 0);
    endtask

    task automatic t_disk_write;
        do_start(0, 2'd1, 2, 5, 0);
        chk("R2", status, 8'h80);
        chk("R2", irq, 0);
        chk("R2", active, 1);
        send_desc(32'h1000, 512);
        serve("R5 R6 write", 1, 2560, 512, 0, 1);
        send_desc(32'h2000, 512);
        serve("R5 R6 write", 1, 3072, 512, 0, 0);
        wait_end("R3", 8'h50);
    endtask

    task automatic t_ignore_start;
        do_start(0, 2'd0, 2, 10, 0);
        send_desc(32'h10, 512);
        serve("R5 read", 0, 5120, 512, 0, 0);
        do_start(1, 2'd0, 0, 0, 9999);
        chk("R2 ignored", status, 8'h80);
        send_desc(32'h20, 512);
        serve("R2 ignored", 0, 5632, 512, 0, 0);
        wait_end("R3", 8'h50);
    endtask

    task automatic t_zero_len;
        do_start(0, 2'd0, 1, 0, 0);
        send_desc(32'h30, 0);
        chk("R9", sto_req_valid, 0);
        chk("R9", desc_ready, 1);
        send_desc(32'h40, 600);
        serve("R3 overlong", 0, 0, 600, 0, 0);
        wait_end("R3", 8'h50);
    endtask

    task automatic t_trim;
        do_start(0, 2'd2, 1, 1, 0);
        send_desc(32'h50, 512);
        serve("R6 trim", 2, 512, 512, 0, 0);
        wait_end("R3", 8'h50);
    endtask

    task automatic t_packet;
        do_start(1, 2'd1, 0, 3, 4096);
        send_desc(32'h60, 2048);
        serve("R5 R6 packet", 0, 6144, 2048, 0, 0);
        @(negedge clk);
        chk("R4", active, 1);
        chk("R4", desc_ready, 1);
        send_desc(32'h70, 2048);
        serve("R5 packet", 0, 8192, 2048, 0, 0);
        wait_end("R4", 8'h50);
    endtask

    task automatic t_copy;
        do_start(1, 2'd0, 0, 32'hFFFF_FFFF, 100);
        send_desc(32'h80, 256);
        serve("R10", 3, 0, 100, 0, 0);
        wait_end("R10", 8'h50);
    endtask

    task automatic t_error;
        do_start(0, 2'd0, 2, 7, 0);
        send_desc(32'h90, 512);
        serve("R11", 0, 3584, 512, 1, 0);
        chk("R11", status, 8'h41);
        chk("R11", irq, 1);
        chk("R11", active, 0);
        chk("R11", desc_ready, 0);
    endtask

    task automatic t_illegal;
        do_start(0, 2'd3, 4, 0, 0);
        chk("R7", status, 8'h41);
        chk("R7", irq, 1);
        chk("R7", active, 0);
    endtask

    task automatic t_parked;
        desc_addr = 32'hA0; desc_len = 16'd512; desc_valid = 1'b1;
        repeat (3) @(negedge clk);
        chk("R8", desc_ready, 0);
        chk("R8", desc_parked, 1);
        chk("R8", sto_req_valid, 0);
        do_start(0, 2'd0, 1, 2, 0);
        for (int n = 0; n < 50 && !desc_ready; n++) @(negedge clk);
        @(negedge clk);
        desc_valid = 1'b0;
        serve("R8 resumed", 0, 1024, 512, 0, 0);
        wait_end("R3", 8'h50);
    endtask

    task automatic t_nsect0;
        do_start(0, 2'd0, 0, 0, 0);
        wait_end("R3 empty", 8'h50);
        chk("R3 empty", sto_req_valid, 0);
    endtask

    initial begin
        #(5.0 * 150000);
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        rst = 1'b1; start = 0; start_packet = 0; start_cmd = 0; start_nsect = 0;
        start_lba = 0; start_pkt_bytes = 0; desc_valid = 0; desc_addr = 0;
        desc_len = 0; sto_req_ready = 0; sto_rsp_valid = 0; sto_rsp_err = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset;
        t_disk_write;
        t_ignore_start;
        t_zero_len;
        t_trim;
        t_packet;
        t_copy;
        t_error;
        t_illegal;
        t_parked;
        t_nsect0;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule